// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Frame Reader

This block is the host-side master for a serial converter that freezes up to six differential inputs at the same instant and then returns one result per channel over a single data line. On a start request it raises the conversion strobe and drives a divided serial clock. It also presents the channel-count code to the converter and clocks in exactly as many 16-clock slots as that code enables. From each slot it keeps a 14-bit field and hands it out as a parallel word with the channel number and a one-cycle valid pulse.

A range flag tells the reader whether the converter runs in the single-ended-style unipolar range or the symmetric bipolar range. The raw codes are offset binary in both ranges. In bipolar mode the reader turns each word into two's complement by inverting its top bit, and it flags the active format next to every word. Each frame is launched by a start pulse and may be cut short by an abort. Between frames the serial clock is parked low, so the converter's acquisition window runs from the last rising clock edge of a frame to the next strobe.

Top module: `msadc_reader`

## Requirements
- R1: While reset is asserted, the strobe, the serial clock and the word valid are all low.
- R2: A frame consists of exactly 16 rising serial clock edges per enabled channel, followed by one falling edge that parks the clock low.
- R3: Channel-count code n (0 to 5) enables channels 0 to n, and codes 6 and 7 enable all six channels. The latched code is driven on the converter select output. Words appear in ascending channel order with indices 0 to count-1.
- R4: The data line is sampled in the system cycle in which the serial clock is raised. Within each 16-edge slot, the bits at slot positions 1 to 14 (0-based, edge order) form the word, MSB first. Positions 0 and 15 are ignored. The word's valid is high for one cycle, together with the clock-high phase of that slot's 15th edge (position 14).
- R5: The strobe rises with the clock low, one half-period before the first rising edge. It stays high for one full serial clock period and falls together with the first falling edge.
- R6: Each serial clock half-period lasts div system cycles, where div is the latched divider input and a value of 0 acts as 1.
- R7: In unipolar mode the word equals the raw 14-bit field. In bipolar mode bit 13 is inverted. The format flag output (1 = bipolar) equals the mode latched at start.
- R8: An asserted abort sets the strobe and the clock low on the next cycle and suppresses all further words of that frame.
- R9: A start, a divider change, a code change or a mode change during a frame has no effect. These inputs are only latched by a start accepted while idle.
- R10: Between frames the serial clock stays low and no word is produced, whatever the data line does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch one frame (accepted only when idle) |
| abort_i | input | 1 | Stop the current frame at once |
| cfg_sel_i | input | 3 | Channel-count code, latched at start |
| cfg_bipolar_i | input | 1 | Range mode, 1 = bipolar, latched at start |
| cfg_div_i | input | 8 | Serial clock half-period in system cycles, latched at start |
| adc_conv_o | output | 1 | Conversion strobe to the converter |
| adc_sck_o | output | 1 | Serial clock to the converter |
| adc_sel_o | output | 3 | Channel-count code to the converter |
| adc_sdo_i | input | 1 | Serial data from the converter |
| word_valid_o | output | 1 | One-cycle strobe for a completed word |
| word_data_o | output | 14 | Result word, straight binary or two's complement |
| word_chan_o | output | 3 | Channel index of the word |
| word_bipolar_o | output | 1 | Format flag for the word, 1 = two's complement |

## Verification
A behavioural converter model in the bench serves fresh pseudo-random 16-bit slot patterns every frame. Because the ignored edge positions carry random bits, a shifted capture window or an off-by-one slot boundary changes the words. Frames are run with the shortest, a middle and the longest channel-count codes, with divider values 0, 1, 2 and 3, and in both range modes. This separates frame-length decoding, clock timing and the MSB conversion. Separate runs inject a mid-frame start with changed configuration and a mid-frame abort, and drive random junk on the data line while idle. These runs show that only an idle start latches anything and that nothing is captured outside a frame.

// File: rtl/msadc_pkg.sv
package msadc_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } msadc_state_e;

    // Number of channels enabled by a count code: code n -> n+1, saturating at nch.
    function automatic int unsigned msadc_active(input int unsigned code, input int unsigned nch);
        if (code + 1 >= nch) return nch;
        return code + 1;
    endfunction

endpackage

// File: rtl/msadc_tick.sv
module msadc_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] lim;

    always_comb begin
        lim    = (div_i == '0) ? DIV_W'(1) : div_i;
        tick_o = run_i && (cnt_q == lim - DIV_W'(1));
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && lim > DIV_W'(1)) |=> !tick_o); // R6

endmodule

// File: rtl/msadc_capture.sv
module msadc_capture #(
    parameter int RES    = 14,
    parameter int SLOT_W = 4,
    parameter int CH_W   = 3,
    parameter int OFS    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en_i,
    input  logic [SLOT_W-1:0] pos_i,
    input  logic [CH_W-1:0]   slot_i,
    input  logic              sdo_i,
    input  logic              bipolar_i,
    output logic              valid_o,
    output logic [RES-1:0]    data_o,
    output logic [CH_W-1:0]   chan_o
);
    localparam logic [SLOT_W-1:0] FIRST    = SLOT_W'(OFS);
    localparam logic [SLOT_W-1:0] LAST     = SLOT_W'(OFS + RES - 1);
    localparam logic [RES-1:0]    MSB_MASK = {1'b1, {(RES-1){1'b0}}};

    typedef struct packed {
        logic [RES-1:0]  sh;
        logic            valid;
        logic [RES-1:0]  data;
        logic [CH_W-1:0] chan;
    } cap_t;

    cap_t d, q;
    logic [RES-1:0] nxt_sh;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        nxt_sh  = {q.sh[RES-2:0], sdo_i};
        if (shift_en_i && pos_i >= FIRST && pos_i <= LAST) begin
            d.sh = nxt_sh;
            if (pos_i == LAST) begin
                d.valid = 1'b1;
                d.data  = bipolar_i ? (nxt_sh ^ MSB_MASK) : nxt_sh;
                d.chan  = slot_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign valid_o = q.valid;
    assign data_o  = q.data;
    assign chan_o  = q.chan;

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |=> !q.valid); // R4

endmodule

// File: rtl/msadc_reader.sv
module msadc_reader #(
    parameter int NCH      = 6,
    parameter int RES      = 14,
    parameter int SLOT     = 16,
    parameter int SLOT_OFS = 1,
    parameter int DIV_W    = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           abort_i,
    input  logic [2:0]     cfg_sel_i,
    input  logic           cfg_bipolar_i,
    input  logic [DIV_W-1:0] cfg_div_i,
    output logic           adc_conv_o,
    output logic           adc_sck_o,
    output logic [2:0]     adc_sel_o,
    input  logic           adc_sdo_i,
    output logic           word_valid_o,
    output logic [RES-1:0] word_data_o,
    output logic [2:0]     word_chan_o,
    output logic           word_bipolar_o
);
    import msadc_pkg::*;

    localparam int CH_W   = 3;
    localparam int SLOT_W = $clog2(SLOT);
    localparam int EDGE_W = $clog2(NCH * SLOT + 1);

    typedef struct packed {
        msadc_state_e      st;
        logic              sck;
        logic              conv;
        logic [EDGE_W-1:0] edges;
        logic [EDGE_W-1:0] total;
        logic [2:0]        sel;
        logic              bip;
        logic [DIV_W-1:0]  div;
    } ctl_t;

    ctl_t d, q;
    logic tick;
    logic rise;
    logic [SLOT_W-1:0] pos;
    logic [CH_W-1:0]   slot;

    msadc_tick #(.DIV_W(DIV_W)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (q.st == ST_RUN),
        .div_i  (q.div),
        .tick_o (tick)
    );

    always_comb begin
        d    = q;
        rise = 1'b0;
        if (abort_i) begin
            d.st   = ST_IDLE;
            d.sck  = 1'b0;
            d.conv = 1'b0;
        end else begin
            case (q.st)
                ST_IDLE: begin
                    if (start_i) begin
                        d.st    = ST_RUN;
                        d.conv  = 1'b1;
                        d.sck   = 1'b0;
                        d.edges = '0;
                        d.sel   = cfg_sel_i;
                        d.bip   = cfg_bipolar_i;
                        d.div   = cfg_div_i;
                        d.total = EDGE_W'(msadc_active(int'(cfg_sel_i), NCH) * SLOT);
                    end
                end
                default: begin
                    if (tick) begin
                        d.sck = !q.sck;
                        if (!q.sck) begin
                            rise    = 1'b1;
                            d.edges = q.edges + EDGE_W'(1);
                        end else begin
                            if (q.edges == EDGE_W'(1)) d.conv = 1'b0;
                            if (q.edges == q.total)    d.st   = ST_IDLE;
                        end
                    end
                end
            endcase
        end
        pos  = SLOT_W'(q.edges % EDGE_W'(SLOT));
        slot = CH_W'(q.edges / EDGE_W'(SLOT));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    msadc_capture #(
        .RES    (RES),
        .SLOT_W (SLOT_W),
        .CH_W   (CH_W),
        .OFS    (SLOT_OFS)
    ) cap_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en_i (rise),
        .pos_i      (pos),
        .slot_i     (slot),
        .sdo_i      (adc_sdo_i),
        .bipolar_i  (q.bip),
        .valid_o    (word_valid_o),
        .data_o     (word_data_o),
        .chan_o     (word_chan_o)
    );

    assign adc_conv_o     = q.conv;
    assign adc_sck_o      = q.sck;
    assign adc_sel_o      = q.sel;
    assign word_bipolar_o = q.bip;

    AST_CONV_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_conv_o) |-> !adc_sck_o); // R5
    AST_NO_RESTROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN) |=> !$rose(adc_conv_o)); // R9
    AST_EDGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        q.edges <= q.total); // R2
    AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> ((int'(word_chan_o) + 1) * SLOT <= int'(q.total))); // R3
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!adc_conv_o && !adc_sck_o && !word_valid_o)); // R8

endmodule

// File: tb/msadc_reader_tb.sv
module msadc_reader_tb_top;
    localparam int OFS = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, abort_i = 1'b0;
    logic [2:0]  cfg_sel_i = 3'd0;
    logic        cfg_bipolar_i = 1'b0;
    logic [7:0]  cfg_div_i = 8'd1;
    logic        adc_sdo_i = 1'b0;
    logic        adc_conv_o, adc_sck_o, word_valid_o, word_bipolar_o;
    logic [2:0]  adc_sel_o, word_chan_o;
    logic [13:0] word_data_o;

    int vectors = 0, errors = 0;
    bit done = 0;
    string phase = "R1 reset";

    // reference model state
    int m_busy = 0, m_t = 0, m_D = 1, m_N = 16;
    logic [2:0] m_sel = 0;
    logic m_bip = 0;
    logic [15:0] m_words [0:5];

    always #10 clk = ~clk;

    msadc_reader dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
        .cfg_sel_i(cfg_sel_i), .cfg_bipolar_i(cfg_bipolar_i), .cfg_div_i(cfg_div_i),
        .adc_conv_o(adc_conv_o), .adc_sck_o(adc_sck_o), .adc_sel_o(adc_sel_o),
        .adc_sdo_i(adc_sdo_i), .word_valid_o(word_valid_o), .word_data_o(word_data_o),
        .word_chan_o(word_chan_o), .word_bipolar_o(word_bipolar_o)
    );

    task automatic check(input string req, input string sig, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s [%s] %s: actual=%0h expected=%0h at %0t", req, phase, sig, act, exp, $time);
        end
    endtask

    task automatic model_step(input bit st, input bit ab);
        if (ab) m_busy = 0;
        else if (m_busy != 0) begin
            m_t++;
            if (m_t == 2 * m_N * m_D) m_busy = 0;
        end else if (st) begin
            int cnt;
            m_busy = 1; m_t = 0;
            m_sel = cfg_sel_i; m_bip = cfg_bipolar_i;
            m_D = (cfg_div_i == 0) ? 1 : int'(cfg_div_i);
            cnt = (cfg_sel_i >= 5) ? 6 : int'(cfg_sel_i) + 1;
            m_N = 16 * cnt;
            for (int c = 0; c < 6; c++) m_words[c] = 16'($urandom);
        end
    endtask

    task automatic compare();
        bit e_conv, e_sck, e_val;
        int k, ch;
        logic [13:0] e_data;
        e_conv = 0; e_sck = 0; e_val = 0; ch = 0; e_data = 0;
        if (m_busy != 0) begin
            e_conv = (m_t < 2 * m_D);
            e_sck  = ((m_t / m_D) % 2) == 1;
            if (e_sck && (m_t % m_D) == 0) begin
                k = (m_t / m_D + 1) / 2;
                if ((k - 1) % 16 == OFS + 13) begin
                    e_val  = 1;
                    ch     = (k - 1) / 16;
                    e_data = m_words[ch][15-OFS -: 14] ^ (m_bip ? 14'h2000 : 14'h0);
                end
            end
        end
        check("R5", "adc_conv_o", int'(adc_conv_o), int'(e_conv));
        check("R6", "adc_sck_o", int'(adc_sck_o), int'(e_sck));
        check("R4", "word_valid_o", int'(word_valid_o), int'(e_val));
        check("R3", "adc_sel_o", int'(adc_sel_o), int'(m_sel));
        check("R7", "word_bipolar_o", int'(word_bipolar_o), int'(m_bip));
        if (e_val && word_valid_o) begin
            check("R3", "word_chan_o", int'(word_chan_o), ch);
            check("R7", "word_data_o", int'(word_data_o), int'(e_data));
        end
    endtask

    task automatic drive_sdo();
        int nxt;
        if (m_busy != 0) begin
            nxt = (m_t / m_D + 1) / 2 + 1;
            if (nxt <= m_N) adc_sdo_i = m_words[(nxt-1)/16][15 - ((nxt-1) % 16)];
            else            adc_sdo_i = 1'($urandom);
        end else adc_sdo_i = 1'($urandom);  // R10: junk while idle
    endtask

    task automatic cyc(input bit st, input bit ab);
        start_i = st; abort_i = ab;
        @(posedge clk);
        model_step(st, ab);
        @(negedge clk);
        start_i = 0; abort_i = 0;
        compare();
        drive_sdo();
    endtask

    task automatic run_frame(input logic [2:0] sel, input bit bip, input logic [7:0] div);
        cfg_sel_i = sel; cfg_bipolar_i = bip; cfg_div_i = div;
        cyc(1, 0);
        while (m_busy != 0) cyc(0, 0);
        repeat (10) cyc(0, 0);
    endtask

    initial begin
        for (int c = 0; c < 6; c++) m_words[c] = 16'h0;
        repeat (3) @(negedge clk);
        check("R1", "adc_conv_o", int'(adc_conv_o), 0);
        check("R1", "adc_sck_o", int'(adc_sck_o), 0);
        check("R1", "word_valid_o", int'(word_valid_o), 0);
        rst_n = 1;
        repeat (4) cyc(0, 0);

        phase = "R2 R3 six channels unipolar div1";
        run_frame(3'd5, 0, 8'd1);
        phase = "R7 R6 one channel bipolar div3";
        run_frame(3'd0, 1, 8'd3);
        phase = "R3 R6 code7 div0";
        run_frame(3'd7, 1, 8'd0);
        phase = "R2 code3 unipolar div2";
        run_frame(3'd3, 0, 8'd2);

        phase = "R9 mid-frame start and config change";
        cfg_sel_i = 3'd2; cfg_bipolar_i = 0; cfg_div_i = 8'd2;
        cyc(1, 0);
        repeat (40) cyc(0, 0);
        cfg_sel_i = 3'd6; cfg_bipolar_i = 1; cfg_div_i = 8'd5;
        cyc(1, 0);
        while (m_busy != 0) cyc(0, 0);

        phase = "R10 idle gap";
        repeat (60) cyc(0, 0);

        phase = "R8 abort mid-frame";
        cfg_sel_i = 3'd6; cfg_bipolar_i = 0; cfg_div_i = 8'd2;
        cyc(1, 0);
        repeat (100) cyc(0, 0);
        cyc(0, 1);
        repeat (30) cyc(0, 0);
        phase = "R8 frame after abort";
        run_frame(3'd6, 1, 8'd1);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule